// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block takes one 12-bit converter code through a start/busy handshake and sends it to a serial digital-to-analogue converter as a single 16-bit SPI write. A fixed 4-bit command code, 0011, is placed ahead of the data. The frame goes out as two bytes, one straight after the other, on one continuous serial clock. Chip select then rises, and that rising edge tells the converter to move the new code to its output.

The host pulses `start` with `code` valid while `busy` is low. The block owns the chip select, serial clock and serial data lines until the frame ends. The serial clock runs at the system clock divided by `SCK_DIV`, which must be even and at least 2. The reset source must release `rst_n` synchronously to `clk`.

Top module: `dac_frame_tx`

## Requirements
- R1: After reset and between frames, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `mosi` is 0.
- R2: Each frame carries exactly 16 bits, most significant first, sampled on `sclk` rising edges. Frame bits 15:12 are 0011, bits 11:8 are `code[11:8]` (the first byte ends here) and bits 7:0 are `code[7:0]` (the second byte).
- R3: SPI mode 0. `sclk` idles low. `mosi` changes only in the cycle where `sclk` falls, or when `cs_n` falls, and it holds steady while `sclk` is high.
- R4: `cs_n` stays low across both bytes. The first `sclk` rising edge comes `SCK_DIV` clock cycles after `cs_n` falls. `cs_n` rises `SCK_DIV` cycles after the last `sclk` falling edge, and `sclk` is never high while `cs_n` is high.
- R5: The second byte follows the first with no gap: all 16 rising edges of a frame are spaced exactly `SCK_DIV` cycles apart.
- R6: `busy` is 1 from the cycle after a start is accepted until the cycle in which `cs_n` returns high, and it equals the inverse of `cs_n`.
- R7: A `start` pulse while `busy` is 1 is ignored. The frame in flight keeps its data, and no extra frame follows.
- R8: `sclk` is high for exactly `SCK_DIV/2` cycles, and low for `SCK_DIV/2` cycles between two edges of one frame.
- R9: The full 12-bit field is sent unchanged, including the extremes 0x000 and 0xFFF (4096 levels).
- R10: When `start` is sampled high while idle, `cs_n` falls and `busy` rises on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request to send `code`; taken only while idle |
| code | input | CODE_W (12) | Converter code to transmit |
| busy | output | 1 | High while a frame is in progress |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data, MSB first |

## Verification
The checker watches several things on every cycle: that the serial clock stays low while chip select is high, that data holds while the clock is high or rising, that each high phase lasts half the divider, that a start taken while idle pulls chip select low on the next edge, and that chip select never rises straight out of a high clock. Other properties depend on a whole frame and only the bench scenarios can show them. These are the decoded 16-bit word with its command nibble, the byte-boundary spacing, the lead and trail gaps around chip select, and the fact that a start pulse in the middle of a frame leaves the data and the frame count unchanged. Those scenarios run against a behavioural cycle model.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } tx_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/dac_tx_clkgen.sv
module dac_tx_clkgen #(
  parameter int SCK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int HALF = SCK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] WRAP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == WRAP);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dac_tx_shifter.sv
module dac_tx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              shift,
  output logic              sdo,
  output logic              last_bit
);
  localparam int LW = $clog2(BYTE_W + 1);
  localparam logic [LW-1:0] FULL = LW'(BYTE_W);
  localparam logic [LW-1:0] ONE  = LW'(1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [LW-1:0]     left_q, left_d;

  assign sdo      = sh_q[BYTE_W-1];
  assign last_bit = (left_q == ONE);

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = load_byte;
      left_d = FULL;
    end else if (shift) begin
      sh_d = {sh_q[BYTE_W-2:0], 1'b0};
      if (left_q != '0) left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load || shift) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/dac_tx_ctrl.sv
module dac_tx_ctrl
  import dac_tx_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CTRL_W = 4,
  parameter logic [CTRL_W-1:0] CTRL_CODE = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              tick,
  input  logic              last_bit,
  output logic              run,
  output logic              sclk,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte,
  output logic              shift
);
  localparam int FRAME_W = CTRL_W + CODE_W;
  localparam int NBYTES  = FRAME_W / BYTE_W;
  localparam int HP_END  = 2 * FRAME_W + 2;
  localparam int HPW     = $clog2(HP_END + 1);
  localparam int BW      = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [HPW-1:0] HP_END_V  = HPW'(HP_END);
  localparam logic [HPW-1:0] HP_BITS_V = HPW'(2 * FRAME_W);
  localparam logic [HPW-1:0] HP_TWO_V  = HPW'(2);
  localparam logic [BW-1:0]  LAST_BYTE = BW'(NBYTES - 1);

  tx_state_e          state_q, state_d;
  logic [HPW-1:0]     hp_q, hp_d;
  logic [BW-1:0]      byte_q, byte_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               sclk_q, sclk_d;
  logic [FRAME_W-1:0] new_frame;
  logic               fall_ev;

  assign new_frame = {CTRL_CODE, code};
  assign run       = (state_q == ST_BUSY);
  assign sclk      = sclk_q;
  assign fall_ev   = tick && !hp_q[0] && (hp_q >= HP_TWO_V) && (hp_q <= HP_BITS_V);

  always_comb begin
    state_d   = state_q;
    hp_d      = hp_q;
    byte_d    = byte_q;
    frame_d   = frame_q;
    sclk_d    = sclk_q;
    load      = 1'b0;
    shift     = 1'b0;
    load_byte = frame_q[FRAME_W-1 -: BYTE_W];
    if (state_q == ST_IDLE) begin
      if (start) begin
        state_d   = ST_BUSY;
        hp_d      = '0;
        byte_d    = '0;
        frame_d   = new_frame << BYTE_W;
        sclk_d    = 1'b0;
        load      = 1'b1;
        load_byte = new_frame[FRAME_W-1 -: BYTE_W];
      end
    end else if (tick) begin
      if (hp_q == HP_END_V) begin
        state_d = ST_IDLE;
        hp_d    = '0;
        sclk_d  = 1'b0;
      end else begin
        hp_d   = hp_q + 1'b1;
        sclk_d = hp_q[0] && (hp_q < HP_BITS_V);
      end
      if (fall_ev) begin
        if (last_bit && (byte_q != LAST_BYTE)) begin
          byte_d  = byte_q + 1'b1;
          frame_d = frame_q << BYTE_W;
          load    = 1'b1;
        end else begin
          shift = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hp_q    <= '0;
      byte_q  <= '0;
      frame_q <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hp_q    <= hp_d;
      byte_q  <= byte_d;
      frame_q <= frame_d;
      sclk_q  <= sclk_d;
    end
  end
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx #(
  parameter int SCK_DIV = 4,
  parameter int CODE_W  = 12,
  parameter int CTRL_W  = 4,
  parameter logic [CTRL_W-1:0] CTRL_CODE = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi
);
  localparam int BW8 = dac_tx_pkg::BYTE_W;

  logic           run, tick, load, shift, last_bit;
  logic [BW8-1:0] load_byte;

  dac_tx_clkgen #(.SCK_DIV(SCK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  dac_tx_ctrl #(.CODE_W(CODE_W), .CTRL_W(CTRL_W), .CTRL_CODE(CTRL_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code), .tick(tick),
    .last_bit(last_bit), .run(run), .sclk(sclk), .load(load),
    .load_byte(load_byte), .shift(shift)
  );

  dac_tx_shifter #(.BYTE_W(BW8)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .shift(shift), .sdo(mosi), .last_bit(last_bit)
  );

  assign busy = run;
  assign cs_n = ~run;
endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk #(
  parameter int SCK_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);
  localparam int HALF = SCK_DIV / 2;
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= 0;
    else if (sclk) hi_cnt <= hi_cnt + 1;
    else           hi_cnt <= 0;
  end

  // R1
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R3
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R3
  mosi_hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  // R8
  sclk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == HALF));

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (!cs_n && busy));

  // R4
  cs_release_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !$past(sclk));
endmodule

bind dac_frame_tx dac_frame_tx_chk #(.SCK_DIV(SCK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
);

// File: tb/sim_dac_frame_tx.sv
`timescale 1ns/1ps
module sim_dac_frame_tx;
  localparam int DIV = 6;
  localparam int H   = DIV / 2;

  logic clk, rst_n, start;
  logic [11:0] code;
  logic busy, cs_n, sclk, mosi;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int frames_done = 0;

  dac_frame_tx #(.SCK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          m_act = 1'b0;
  int          m_c = 0;
  logic [15:0] m_frame = '0;
  logic [15:0] exp_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 1'b0;
      m_c   = 0;
    end else if (!m_act) begin
      if (start) begin
        m_act   = 1'b1;
        m_c     = 0;
        m_frame = {4'b0011, code};
        exp_q.push_back(m_frame);
      end
    end else begin
      m_c++;
      if (m_c == 35 * H) m_act = 1'b0;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int  hp;
      bit  e_sclk;
      bit  e_mosi;
      hp     = m_c / H;
      e_sclk = m_act && hp >= 2 && hp <= 32 && (hp % 2 == 0);
      e_mosi = m_act && hp <= 32 && m_frame[15 - ((hp == 0) ? 0 : (hp - 1) / 2)];
      chk(cs_n == !m_act, "R4 cs_n vs model", cs_n, !m_act);
      chk(busy == m_act,  "R6 busy vs model", busy, m_act);
      chk(sclk == e_sclk, "R8 sclk vs model", sclk, e_sclk);
      chk(mosi == e_mosi, "R3 mosi vs model", mosi, e_mosi);
    end
  end

  // Frame decoder at the pins
  logic [15:0] cap;
  int nb, t_cs, t_rise, t_fall;
  logic p_cs = 1'b1, p_sclk = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        cap  = '0;
        nb   = 0;
        t_cs = cyc;
      end
      if (!p_sclk && sclk) begin
        if (nb == 0) chk(cyc - t_cs == DIV, "R4 lead gap", cyc - t_cs, DIV);
        else         chk(cyc - t_rise == DIV, "R5 rise spacing", cyc - t_rise, DIV);
        t_rise = cyc;
        cap = {cap[14:0], mosi};
        nb++;
      end
      if (p_sclk && !sclk) t_fall = cyc;
      if (!p_cs && cs_n) begin
        logic [15:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
        chk(nb == 16, "R2 bit count", nb, 16);
        chk(cap === e, "R2 frame word", cap, e);
        chk(cyc - t_fall == DIV, "R4 trail gap", cyc - t_fall, DIV);
        frames_done++;
      end
      p_cs   = cs_n;
      p_sclk = sclk;
    end
  end

  task automatic send(input logic [11:0] c, input bit poke);
    start = 1'b1;
    code  = c;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !cs_n, "R10 accept latency", {busy, cs_n}, 2'b10);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      code  = 12'h777;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    code  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(mosi == 1'b0, "R1 reset mosi", mosi, 0);
    send(12'hA5C, 1'b0);          // R2 mixed pattern
    send(12'h000, 1'b0);          // R9 lowest code
    send(12'hFFF, 1'b0);          // R9 highest code, back to back
    repeat (4) @(negedge clk);
    send(12'h3C1, 1'b1);          // R7 start ignored while busy
    repeat (10) @(negedge clk);
    chk(cs_n && !busy && !sclk && !mosi, "R1 idle between frames", {cs_n, busy, sclk, mosi}, 4'b1000);
    chk(frames_done == 4, "R7 frame count", frames_done, 4);
    chk(exp_q.size() == 0, "R7 no extra frame", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule